// File: doc/BRIEF.md
# Keyed Manipulation-Detection Tag Checker

This block decides whether a reconstructed secret word has been tampered with before it is handed on. The incoming word carries three information fields and one tag field, each of width W (32 by default, so the word is 128 bits). The block holds two secret key elements of GF(2^W) in a private register that cannot be read back. On request it recomputes the tag from the information fields and the key, compares it with the received tag, and either releases the 96 information bits or raises an error with the secret output held at zero.

The tag is a keyed polynomial over GF(2^W). Because it depends on a random key that never leaves the block, a party who knows the secret still cannot forge a new codeword with certainty. The key is written once through a write-only port and then frozen by a lock bit. Before the lock is set, every check fails. A single multiplier is shared across a fixed seven-step schedule, so each check takes seven clock cycles. The same RTL, built with W = 3 and the polynomial x^3 + x + 1, gives a 12-bit test variant.

Top module: `amd_tag_checker`

## Requirements
- R1: `word_in` is laid out as {y0, y1, y2, t}: y0 occupies the top W bits and t the bottom W bits. When the check passes, `secret_vld` = 1, `err` = 0 and `secret_out` = {y0, y1, y2}.
- R2: The check passes when t equals y0·x0 + y1·x1 + y2·x0·x1 + x0^3 + x1^3. All arithmetic is in GF(2^W). For W = 32 the field is reduced by x^32 + x^7 + x^3 + x^2 + 1 (POLY = 32'h0000008D).
- R3: On any tag mismatch, `err` = 1, `secret_vld` = 0 and `secret_out` = 0. `err` and `secret_vld` are never high together.
- R4: A start is accepted at a rising edge while the block is idle. `done` is then high for exactly one cycle, following the seventh rising edge after that edge. `err`, `secret_vld` and `secret_out` change only at that edge and hold their values until the next `done`.
- R5: A `start` that arrives while a check is in progress is ignored. It neither changes the result nor produces an extra `done`.
- R6: A write (`key_wr` = 1) loads `key_x0` and `key_x1` while the key is unlocked. `key_lock` = 1 together with a write sets the lock. After the lock is set, all further writes are ignored.
- R7: A check that is accepted while the key is unlocked always ends with `err` = 1, even if the tag would match.
- R8: With W = 3 and POLY = 3'b011 (x^3 + x + 1), and with x0 = 010 and x1 = 110, the word 001_001_100_001 passes. Any other tag value for the same information bits fails.
- R9: After reset, `done`, `err` and `secret_vld` are 0, `secret_out` is 0, and the key is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Key write strobe |
| key_lock | input | 1 | Sets the lock together with a write |
| key_x0 | input | W | First key element |
| key_x1 | input | W | Second key element |
| start | input | 1 | Request a check of `word_in` |
| word_in | input | 4*W | Word to check: {y0, y1, y2, t} |
| done | output | 1 | One-cycle pulse when a result is ready |
| err | output | 1 | Tampering detected or key not locked |
| secret_vld | output | 1 | Secret released |
| secret_out | output | 3*W | {y0, y1, y2} on pass, zero otherwise |

## Verification
Each result is due seven rising edges after the edge that accepts `start`. The bench's reference model counts that interval on its own cycle counter and compares `done`, `err`, `secret_vld` and `secret_out` at every falling edge, so a result that comes one cycle early or late is a miscompare. The directed runs also sample `done` at edge six and edge seven, and count `done` pulses across an ignored mid-check start. The 12-bit variant is run against the hand-worked GF(8) codeword.

// File: rtl/amd_pkg.sv
package amd_pkg;
  localparam int NSTEPS = 7;
  localparam int STEP_W = $clog2(NSTEPS);

  // Schedule of the shared multiplier; the last step compares.
  typedef enum logic [STEP_W-1:0] {
    ST_XX  = 3'd0,
    ST_Y2  = 3'd1,
    ST_Y0  = 3'd2,
    ST_Y1  = 3'd3,
    ST_C0  = 3'd4,
    ST_C1  = 3'd5,
    ST_CMP = 3'd6
  } step_e;
endpackage

// File: rtl/amd_gf_mult.sv
module amd_gf_mult #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 'h8D
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  logic [W-1:0] sh;
  logic [W-1:0] acc;

  // Shift-and-add over the bits of b; a is multiplied by x each step.
  always_comb begin
    sh  = a;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[W-2:0], 1'b0} ^ (sh[W-1] ? POLY : '0);
    end
    p = acc;
  end
endmodule

// File: rtl/amd_gf_square.sv
module amd_gf_square #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 'h8D
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] q
);
  localparam int SW = 2 * W - 1;
  logic [SW-1:0] spread;

  // Squaring spreads the bits to the even positions; the upper half is then folded down.
  always_comb begin
    spread = '0;
    for (int i = 0; i < W; i++) spread[2*i] = a[i];
    for (int i = SW - 1; i >= W; i--) begin
      if (spread[i]) spread[i-W +: W] = spread[i-W +: W] ^ POLY;
    end
    q = spread[W-1:0];
  end
endmodule

// File: rtl/amd_key_vault.sv
module amd_key_vault #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         lock_req,
  input  logic [W-1:0] din0,
  input  logic [W-1:0] din1,
  output logic [W-1:0] k0,
  output logic [W-1:0] k1,
  output logic         locked
);
  logic         wr_ok;
  logic [W-1:0] k0_n, k1_n;
  logic         locked_n;

  assign wr_ok = wr_en & ~locked;

  always_comb begin
    k0_n     = k0;
    k1_n     = k1;
    locked_n = locked;
    if (wr_ok) begin
      k0_n     = din0;
      k1_n     = din1;
      locked_n = lock_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k0     <= '0;
      k1     <= '0;
      locked <= 1'b0;
    end else if (wr_ok) begin
      k0     <= k0_n;
      k1     <= k1_n;
      locked <= locked_n;
    end
  end
endmodule

// File: rtl/amd_step_seq.sv
module amd_step_seq
  import amd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              last
);
  logic              busy_n;
  logic [STEP_W-1:0] step_n;

  assign accept = start & ~busy;
  assign last   = busy & (step == STEP_W'(NSTEPS - 1));

  always_comb begin
    busy_n = busy;
    step_n = step;
    if (accept) begin
      busy_n = 1'b1;
      step_n = '0;
    end else if (busy) begin
      if (last) begin
        busy_n = 1'b0;
        step_n = '0;
      end else begin
        step_n = step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      busy <= busy_n;
      step <= step_n;
    end
  end
endmodule

// File: rtl/amd_tag_checker.sv
module amd_tag_checker
  import amd_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 'h8D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           key_wr,
  input  logic           key_lock,
  input  logic [W-1:0]   key_x0,
  input  logic [W-1:0]   key_x1,
  input  logic           start,
  input  logic [4*W-1:0] word_in,
  output logic           done,
  output logic           err,
  output logic           secret_vld,
  output logic [3*W-1:0] secret_out
);
  localparam int SEC_W = 3 * W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [W-1:0] key_k0, key_k1;
  logic         key_locked;

  amd_key_vault #(.W(W)) u_vault (
    .clk(clk), .rst_n(rst_i_n), .wr_en(key_wr), .lock_req(key_lock),
    .din0(key_x0), .din1(key_x1), .k0(key_k0), .k1(key_k1), .locked(key_locked)
  );

  logic              accept, busy, last;
  logic [STEP_W-1:0] step_w;
  step_e             cur_step;

  amd_step_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .accept(accept),
    .busy(busy), .step(step_w), .last(last)
  );
  assign cur_step = step_e'(step_w);

  // Word captured at the accepting edge.
  logic [W-1:0] y0_q, y1_q, y2_q, rtag_q;
  logic         lock_snap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y0_q        <= '0;
      y1_q        <= '0;
      y2_q        <= '0;
      rtag_q      <= '0;
      lock_snap_q <= 1'b0;
    end else if (!rst_i_n) begin
      lock_snap_q <= 1'b0;
    end else if (accept) begin
      y0_q        <= word_in[4*W-1 -: W];
      y1_q        <= word_in[3*W-1 -: W];
      y2_q        <= word_in[2*W-1 -: W];
      rtag_q      <= word_in[W-1:0];
      lock_snap_q <= key_locked;
    end
  end

  // One shared multiplier and two squarers.
  logic [W-1:0] sq0, sq1, mul_a, mul_b, prod;

  amd_gf_square #(.W(W), .POLY(POLY)) u_sq0 (.a(key_k0), .q(sq0));
  amd_gf_square #(.W(W), .POLY(POLY)) u_sq1 (.a(key_k1), .q(sq1));
  amd_gf_mult   #(.W(W), .POLY(POLY)) u_mul (.a(mul_a), .b(mul_b), .p(prod));

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (cur_step)
      ST_XX: begin mul_a = key_k0; mul_b = key_k1; end
      ST_Y2: begin mul_a = y2_q;   mul_b = p01_q;  end
      ST_Y0: begin mul_a = y0_q;   mul_b = key_k0; end
      ST_Y1: begin mul_a = y1_q;   mul_b = key_k1; end
      ST_C0: begin mul_a = sq0;    mul_b = key_k0; end
      ST_C1: begin mul_a = sq1;    mul_b = key_k1; end
      default: begin mul_a = '0;   mul_b = '0;     end
    endcase
  end

  // Accumulation of partial products.
  logic [W-1:0] p01_q, acc_q, p01_n, acc_n;
  logic         prod_en;

  assign prod_en = busy & ~last;

  always_comb begin
    p01_n = p01_q;
    acc_n = acc_q;
    case (cur_step)
      ST_XX:                      p01_n = prod;
      ST_Y2:                      acc_n = prod;
      ST_Y0, ST_Y1, ST_C0, ST_C1: acc_n = acc_q ^ prod;
      default: begin
        p01_n = p01_q;
        acc_n = acc_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p01_q <= '0;
      acc_q <= '0;
    end else if (prod_en) begin
      p01_q <= p01_n;
      acc_q <= acc_n;
    end
  end

  // Compare and result registers.
  logic             tag_ok;
  logic             err_n, vld_n;
  logic [SEC_W-1:0] sec_n;

  always_comb begin
    tag_ok = lock_snap_q & (acc_q == rtag_q);
    err_n  = ~tag_ok;
    vld_n  = tag_ok;
    sec_n  = tag_ok ? {y0_q, y1_q, y2_q} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else if (!rst_i_n) begin
      done <= 1'b0;
    end else begin
      done <= last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err        <= 1'b0;
      secret_vld <= 1'b0;
      secret_out <= '0;
    end else if (!rst_i_n) begin
      err        <= 1'b0;
      secret_vld <= 1'b0;
      secret_out <= '0;
    end else if (last) begin
      err        <= err_n;
      secret_vld <= vld_n;
      secret_out <= sec_n;
    end
  end
endmodule

// File: rtl/amd_tag_checker_chk.sv
module amd_tag_checker_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           err,
  input logic           secret_vld,
  input logic [3*W-1:0] secret_out,
  input logic           key_locked,
  input logic [W-1:0]   k0,
  input logic [W-1:0]   k1,
  input logic           lock_snap,
  input logic           busy
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !secret_vld);

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !secret_vld |-> (secret_out == '0));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_from_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({err, secret_vld, secret_out}));

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_locked |=> key_locked);

  p_key_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_locked |=> $stable({k0, k1}));

  p_unlocked_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lock_snap) |-> err);
endmodule

bind amd_tag_checker amd_tag_checker_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .secret_vld(secret_vld),
  .secret_out(secret_out), .key_locked(key_locked), .k0(key_k0), .k1(key_k1),
  .lock_snap(lock_snap_q), .busy(busy)
);

// File: tb/amd_tag_checker_test.sv
module amd_tag_checker_test;
  localparam int W = 32;
  localparam logic [63:0] PF32 = 64'h1_0000_008D;
  localparam logic [63:0] PF3  = 64'hB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           key_wr, key_lock, start;
  logic [W-1:0]   key_x0, key_x1;
  logic [4*W-1:0] word_in;
  logic           done, err, secret_vld;
  logic [3*W-1:0] secret_out;

  amd_tag_checker uut (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_lock(key_lock),
    .key_x0(key_x0), .key_x1(key_x1), .start(start), .word_in(word_in),
    .done(done), .err(err), .secret_vld(secret_vld), .secret_out(secret_out)
  );

  logic        s_wr, s_lock, s_start;
  logic [2:0]  s_x0, s_x1;
  logic [11:0] s_word;
  logic        s_done, s_err, s_vld;
  logic [8:0]  s_sec;

  amd_tag_checker #(.W(3), .POLY(3'b011)) uut_gf8 (
    .clk(clk), .rst_n(rst_n), .key_wr(s_wr), .key_lock(s_lock),
    .key_x0(s_x0), .key_x1(s_x1), .start(s_start), .word_in(s_word),
    .done(s_done), .err(s_err), .secret_vld(s_vld), .secret_out(s_sec)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Field arithmetic: carry-less product, then long division by the full polynomial.
  function automatic logic [31:0] rmul(input logic [31:0] a, input logic [31:0] b,
                                       input int w, input logic [63:0] pf);
    logic [63:0] c;
    c = '0;
    for (int i = 0; i < w; i++) if (b[i]) c = c ^ (64'(a) << i);
    for (int i = 2*w-2; i >= w; i--) if (c[i]) c = c ^ (pf << (i - w));
    return c[31:0];
  endfunction

  function automatic logic [31:0] rtag(input logic [31:0] y0, y1, y2, x0, x1,
                                       input int w, input logic [63:0] pf);
    return rmul(y0, x0, w, pf) ^ rmul(y1, x1, w, pf)
         ^ rmul(y2, rmul(x0, x1, w, pf), w, pf)
         ^ rmul(rmul(x0, x0, w, pf), x0, w, pf)
         ^ rmul(rmul(x1, x1, w, pf), x1, w, pf);
  endfunction

  function automatic logic [127:0] mkword(input logic [31:0] y0, y1, y2, x0, x1);
    return {y0, y1, y2, rtag(y0, y1, y2, x0, x1, 32, PF32)};
  endfunction

  // Reference model of the main instance, advanced on every rising edge.
  bit           m_busy, m_done, m_err, m_vld, m_locked, m_lsnap;
  int           m_cnt;
  logic [95:0]  m_sec;
  logic [127:0] m_word;
  logic [31:0]  m_k0, m_k1;
  bit           mon_en = 1'b0;
  int           done_pulses = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_vld = 0; m_locked = 0; m_lsnap = 0;
      m_cnt = 0; m_sec = '0; m_word = '0; m_k0 = '0; m_k1 = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 7) begin
          bit pass;
          pass = m_lsnap && (rtag(m_word[127:96], m_word[95:64], m_word[63:32],
                                  m_k0, m_k1, 32, PF32) == m_word[31:0]);
          m_busy = 0;
          m_done = 1;
          m_err  = !pass;
          m_vld  = pass;
          m_sec  = pass ? m_word[127:32] : '0;
        end
      end else if (start) begin
        m_busy  = 1;
        m_cnt   = 0;
        m_word  = word_in;
        m_lsnap = m_locked;
      end
      if (key_wr && !m_locked) begin
        m_k0 = key_x0;
        m_k1 = key_x1;
        if (key_lock) m_locked = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (done) done_pulses++;
      chk("R4", "done vs model", 128'(done), 128'(m_done));
      chk("R3", "err vs model", 128'(err), 128'(m_err));
      chk("R1", "secret_vld vs model", 128'(secret_vld), 128'(m_vld));
      chk("R1", "secret_out vs model", 128'(secret_out), 128'(m_sec));
    end
  end

  task automatic write_key(input logic [31:0] a, input logic [31:0] b, input logic lk);
    @(negedge clk);
    key_wr = 1'b1; key_lock = lk; key_x0 = a; key_x1 = b;
    @(negedge clk);
    key_wr = 1'b0; key_lock = 1'b0;
  endtask

  // Starts a check and returns just after the edge that should raise done.
  task automatic run_main(input logic [127:0] w);
    @(negedge clk);
    start = 1'b1; word_in = w;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "done before seventh edge", 128'(done), 128'(0));
    @(negedge clk);
    chk("R4", "done at seventh edge", 128'(done), 128'(1));
  endtask

  logic [31:0]  kb0, kb1;
  logic [127:0] cw;

  initial begin
    rst_n = 1'b0; key_wr = 0; key_lock = 0; key_x0 = '0; key_x1 = '0;
    start = 0; word_in = '0;
    s_wr = 0; s_lock = 0; s_x0 = '0; s_x1 = '0; s_start = 0; s_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R9: reset state
    chk("R9", "done after reset", 128'(done), 128'(0));
    chk("R9", "err after reset", 128'(err), 128'(0));
    chk("R9", "secret_vld after reset", 128'(secret_vld), 128'(0));
    chk("R9", "secret_out after reset", 128'(secret_out), 128'(0));

    // R7 / R9: the key starts unlocked and all-zero, so a zero tag would match yet must fail.
    run_main({32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'h0});
    chk("R7", "err while unlocked", 128'(err), 128'(1));
    chk("R7", "secret_vld while unlocked", 128'(secret_vld), 128'(0));

    // R6: unlocked write, then locking write, then an ignored write
    write_key(32'hAAAA_5555, 32'h1357_9BDF, 1'b0);
    kb0 = 32'hC0DE_F00D; kb1 = 32'h8BAD_F00D;
    write_key(kb0, kb1, 1'b1);
    write_key(32'h0000_0003, 32'h0000_0005, 1'b1);
    run_main(mkword(32'h1111_2222, 32'h3333_4444, 32'h5555_6666, kb0, kb1));
    chk("R6", "pass with locked key", 128'(secret_vld), 128'(1));
    run_main(mkword(32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h3, 32'h5));
    chk("R6", "post-lock key ignored", 128'(err), 128'(1));

    // R1 / R2: valid codewords
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, b, c;
      a = (i == 0) ? 32'h0 : $urandom();
      b = (i == 1) ? 32'hFFFF_FFFF : $urandom();
      c = $urandom();
      cw = mkword(a, b, c, kb0, kb1);
      run_main(cw);
      chk("R2", "tag accepted", 128'(err), 128'(0));
      chk("R1", "secret released", 128'(secret_out), 128'(cw[127:32]));
    end

    // R3: corrupted y0, y2 and tag
    cw = mkword(32'hDEAD_BEEF, 32'h0BAD_CAFE, 32'h1234_4321, kb0, kb1);
    for (int j = 0; j < 3; j++) begin
      logic [127:0] bad;
      bad = cw ^ (128'h1 << ((j == 0) ? 127 : (j == 1) ? 40 : 0));
      run_main(bad);
      chk("R3", "err on tamper", 128'(err), 128'(1));
      chk("R3", "vld on tamper", 128'(secret_vld), 128'(0));
      chk("R3", "secret masked", 128'(secret_out), 128'(0));
    end

    // R4: result holds after done
    run_main(cw);
    repeat (5) @(negedge clk);
    chk("R4", "result held", 128'({err, secret_vld}), 128'(2'b01));

    // R5: a start in the middle of a check is ignored
    done_pulses = 0;
    @(negedge clk); start = 1'b1; word_in = cw;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    start = 1'b1; word_in = cw ^ 128'h1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5", "first result kept", 128'(secret_vld), 128'(1));
    repeat (12) @(negedge clk);
    chk("R5", "single done pulse", 128'(done_pulses), 128'(1));

    // R8: 12-bit variant
    @(negedge clk); s_wr = 1; s_lock = 1; s_x0 = 3'b010; s_x1 = 3'b110;
    @(negedge clk); s_wr = 0; s_lock = 0;
    chk("R8", "reference tag", 128'(rtag(32'd1, 32'd1, 32'd4, 32'd2, 32'd6, 3, PF3)), 128'(1));
    s_start = 1; s_word = 12'b001_001_100_001;
    @(negedge clk); s_start = 0;
    repeat (7) @(negedge clk);
    chk("R8", "small done", 128'(s_done), 128'(1));
    chk("R8", "small pass", 128'({s_err, s_vld}), 128'(2'b01));
    chk("R8", "small secret", 128'(s_sec), 128'(9'b001_001_100));
    for (int t = 0; t < 8; t++) begin
      if (t != 1) begin
        @(negedge clk); s_start = 1; s_word = {9'b001_001_100, 3'(t)};
        @(negedge clk); s_start = 0;
        repeat (7) @(negedge clk);
        chk("R8", "small wrong tag", 128'({s_err, s_vld}), 128'(2'b10));
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule